// File: doc/BRIEF.md
# Bayer Per-Channel Digital Gain

This block sits in a streaming raw-pixel path behind an image sensor. It multiplies every 10-bit raw pixel by one of four programmable gains. The gain is picked by the pixel's place in the repeating 2x2 colour-filter mosaic. A pixel on an even row and even column is red (R). One on an even row and odd column is green-on-red (Gr). One on an odd row and even column is green-on-blue (Gb). One on an odd row and odd column is blue (B). Rows and columns count from zero at the start of each frame.

Pixels arrive with a valid strobe and with start-of-line and start-of-frame markers. The first pixel of a frame carries both markers. The block follows the mosaic phase with a small state machine that has three states:

- `PH_NO_FRAME`: no frame has started since reset.
- `PH_EVEN_ROW`: the current row is even.
- `PH_ODD_ROW`: the current row is odd.

The state machine moves as follows:

- A start-of-frame pixel moves any state to `PH_EVEN_ROW`.
- A start-of-line pixel without start-of-frame swaps `PH_EVEN_ROW` and `PH_ODD_ROW`.
- A start-of-line pixel leaves `PH_NO_FRAME` unchanged.

Column parity restarts at every line.

Each gain is an unsigned fixed-point number with 3 integer bits and 8 fraction bits. It is loaded through byte writes into a staged copy. The staged copy moves into the working copy at the next frame start. The product is rounded, saturated, and leaves the block two cycles after the pixel entered, with its markers.

Top module: `bayer_gain`

## Requirements
- R1: After reset, `out_valid`, `out_sol` and `out_sof` are 0 and `out_pix` is 0. All four gains reset to 1.0 (0x100), so pixels pass through unchanged.
- R2: Gain write address bits [2:1] pick the channel: 0 = Gr, 1 = R, 2 = B, 3 = Gb. The channel used for a pixel is R at (even row, even column), Gr at (even, odd), Gb at (odd, even) and B at (odd, odd).
- R3: A write with `wr_addr[0]`=0 sets gain bits [7:0] from `wr_data[7:0]`. A write with `wr_addr[0]`=1 sets gain bits [10:8] from `wr_data[2:0]`, and `wr_data[7:3]` is ignored.
- R4: The output value is floor((pixel x gain + 128) / 256), which rounds half up at the eighth fraction bit.
- R5: Any result above 1023 is clamped to 1023.
- R6: Row parity is 0 at a start-of-frame pixel and toggles at every other start-of-line pixel. Column parity is 0 at a start-of-line pixel and toggles after each accepted pixel.
- R7: Gain writes land in a staged copy. The staged values take effect from the next start-of-frame pixel, that pixel included. Pixels before it keep the previous gains.
- R8: Each accepted pixel appears on the outputs exactly 2 cycles after it is presented. Its start-of-line and start-of-frame markers are delayed by the same amount. When `out_valid` is 0, `out_pix` and both markers are 0.
- R9: Valid pixels presented after reset and before the first start-of-frame pixel are discarded and produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel strobe |
| in_sol | input | 1 | First pixel of a line (qualified by in_valid) |
| in_sof | input | 1 | First pixel of a frame (qualified by in_valid) |
| in_pix | input | 10 | Raw input pixel |
| wr_en | input | 1 | Gain byte write strobe |
| wr_addr | input | 3 | Channel in [2:1], byte select in [0] |
| wr_data | input | 8 | Gain byte |
| out_valid | output | 1 | Output pixel strobe |
| out_sol | output | 1 | Delayed start-of-line |
| out_sof | output | 1 | Delayed start-of-frame |
| out_pix | output | 10 | Gained, rounded and clamped pixel |

## Verification
The assertions rely on two properties of the input stream:

- Every start-of-frame pixel also carries start-of-line.
- Markers are only raised together with `in_valid`.

The bench keeps to both. Its line task is the only place that raises a marker, and it raises start-of-frame only on the first pixel of a line, always with `in_valid` set. Random idle gaps, odd line lengths, gain writes in the middle of a frame and a reset in the middle of the stream are all produced within those rules. A bench model of the staged gains, the working gains and the mosaic phase predicts every output cycle.

// File: rtl/bayer_gain_pkg.sv
`timescale 1ns/1ps
package bayer_gain_pkg;

    localparam int PIX_W  = 10;
    localparam int GAIN_W = 11;
    localparam int FRAC_W = 8;
    localparam int NCH    = 4;

    typedef enum logic [1:0] {
        CH_GR = 2'd0,
        CH_R  = 2'd1,
        CH_B  = 2'd2,
        CH_GB = 2'd3
    } bg_chan_e;

    typedef enum logic [1:0] {
        PH_NO_FRAME = 2'd0,
        PH_EVEN_ROW = 2'd1,
        PH_ODD_ROW  = 2'd2
    } bg_phase_e;

    function automatic bg_chan_e chan_of(input logic row, input logic col);
        bg_chan_e c;
        unique case ({row, col})
            2'b00:   c = CH_R;
            2'b01:   c = CH_GR;
            2'b10:   c = CH_GB;
            default: c = CH_B;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bg_gain_bank.sv
`timescale 1ns/1ps
module bg_gain_bank
    import bayer_gain_pkg::*;
#(
    parameter int G_W    = GAIN_W,
    parameter int F_W    = FRAC_W,
    parameter int N_CH   = NCH
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(N_CH):0]      wr_addr,
    input  logic [7:0]                 wr_data,
    input  logic                       frame_load,
    input  logic [$clog2(N_CH)-1:0]    ch_sel,
    output logic [G_W-1:0]             gain
);

    localparam int                 HI_W  = G_W - 8;
    localparam int                 SEL_W = $clog2(N_CH);
    localparam logic [G_W-1:0]     UNITY = G_W'(1) << F_W;

    logic [N_CH-1:0][G_W-1:0] staged_q;
    logic [N_CH-1:0][G_W-1:0] active_q;
    logic                     unused_hi;

    assign unused_hi = ^wr_data[7:HI_W];

    for (genvar i = 0; i < N_CH; i++) begin : g_chan
        logic hit;
        assign hit = wr_en && (wr_addr[SEL_W:1] == SEL_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                staged_q[i] <= UNITY;
            end else if (hit) begin
                if (wr_addr[0]) begin
                    staged_q[i][G_W-1:8] <= wr_data[HI_W-1:0];
                end else begin
                    staged_q[i][7:0] <= wr_data;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                active_q[i] <= UNITY;
            end else if (frame_load) begin
                active_q[i] <= staged_q[i];
            end
        end
    end

    always_comb begin
        if (frame_load) begin
            gain = staged_q[ch_sel];
        end else begin
            gain = active_q[ch_sel];
        end
    end

endmodule

// File: rtl/bg_phase_fsm.sv
`timescale 1ns/1ps
module bg_phase_fsm
    import bayer_gain_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     in_valid,
    input  logic     in_sol,
    input  logic     in_sof,
    output logic     accept,
    output logic     frame_load,
    output bg_chan_e chan
);

    bg_phase_e state_q, state_d;
    logic      col_q, col_d;
    logic      row_now, col_now;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_NO_FRAME;
            col_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            col_q   <= col_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d    = state_q;
        col_now    = in_sol ? 1'b0 : col_q;
        row_now    = 1'b0;
        accept     = in_valid && (in_sof || (state_q != PH_NO_FRAME));
        frame_load = in_valid && in_sof;

        unique case (state_q)
            PH_NO_FRAME: row_now = 1'b0;
            PH_EVEN_ROW: row_now = in_sol;
            PH_ODD_ROW:  row_now = !in_sol;
            default:     row_now = 1'b0;
        endcase
        if (in_sof) begin
            row_now = 1'b0;
        end

        if (in_valid) begin
            if (in_sof) begin
                state_d = PH_EVEN_ROW;
            end else begin
                unique case (state_q)
                    PH_NO_FRAME: state_d = PH_NO_FRAME;
                    PH_EVEN_ROW: state_d = in_sol ? PH_ODD_ROW  : PH_EVEN_ROW;
                    PH_ODD_ROW:  state_d = in_sol ? PH_EVEN_ROW : PH_ODD_ROW;
                    default:     state_d = PH_NO_FRAME;
                endcase
            end
        end

        col_d = accept ? !col_now : col_q;
        chan  = chan_of(row_now, col_now);
    end

endmodule

// File: rtl/bg_mul_sat.sv
`timescale 1ns/1ps
module bg_mul_sat
    import bayer_gain_pkg::*;
#(
    parameter int P_W = PIX_W,
    parameter int G_W = GAIN_W,
    parameter int F_W = FRAC_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           s_valid,
    input  logic           s_sol,
    input  logic           s_sof,
    input  logic [P_W-1:0] s_pix,
    input  logic [G_W-1:0] s_gain,
    output logic           m_valid,
    output logic           m_sol,
    output logic           m_sof,
    output logic [P_W-1:0] m_pix
);

    localparam int             PROD_W = P_W + G_W + 1;
    localparam int             SCL_W  = PROD_W - F_W;
    localparam logic [P_W-1:0] MAXV   = '1;

    logic [PROD_W-1:0] prod;
    logic [SCL_W-1:0]  scaled;
    logic [P_W-1:0]    sat;

    always_comb begin
        prod   = PROD_W'(s_pix) * PROD_W'(s_gain) + (PROD_W'(1) << (F_W - 1));
        scaled = prod[PROD_W-1:F_W];
        sat    = (scaled > SCL_W'(MAXV)) ? MAXV : scaled[P_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_valid <= 1'b0;
            m_sol   <= 1'b0;
            m_sof   <= 1'b0;
            m_pix   <= '0;
        end else begin
            m_valid <= s_valid;
            m_sol   <= s_valid && s_sol;
            m_sof   <= s_valid && s_sof;
            m_pix   <= s_valid ? sat : '0;
        end
    end

endmodule

// File: rtl/bayer_gain.sv
`timescale 1ns/1ps
module bayer_gain
    import bayer_gain_pkg::*;
#(
    parameter int P_W  = PIX_W,
    parameter int G_W  = GAIN_W,
    parameter int F_W  = FRAC_W,
    parameter int N_CH = NCH
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  in_sol,
    input  logic                  in_sof,
    input  logic [P_W-1:0]        in_pix,
    input  logic                  wr_en,
    input  logic [$clog2(N_CH):0] wr_addr,
    input  logic [7:0]            wr_data,
    output logic                  out_valid,
    output logic                  out_sol,
    output logic                  out_sof,
    output logic [P_W-1:0]        out_pix
);

    localparam int SEL_W = $clog2(N_CH);

    logic           accept;
    logic           frame_load;
    bg_chan_e       chan;
    logic [G_W-1:0] gain;

    logic           s1_valid;
    logic           s1_sol;
    logic           s1_sof;
    logic [P_W-1:0] s1_pix;
    logic [G_W-1:0] s1_gain;

    bg_phase_fsm u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sol     (in_sol),
        .in_sof     (in_sof),
        .accept     (accept),
        .frame_load (frame_load),
        .chan       (chan)
    );

    bg_gain_bank #(.G_W(G_W), .F_W(F_W), .N_CH(N_CH)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .frame_load (frame_load),
        .ch_sel     (SEL_W'(chan)),
        .gain       (gain)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_sol   <= 1'b0;
            s1_sof   <= 1'b0;
            s1_pix   <= '0;
            s1_gain  <= '0;
        end else begin
            s1_valid <= accept;
            s1_sol   <= accept && in_sol;
            s1_sof   <= accept && in_sof;
            s1_pix   <= in_pix;
            s1_gain  <= gain;
        end
    end

    bg_mul_sat #(.P_W(P_W), .G_W(G_W), .F_W(F_W)) u_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_valid (s1_valid),
        .s_sol   (s1_sol),
        .s_sof   (s1_sof),
        .s_pix   (s1_pix),
        .s_gain  (s1_gain),
        .m_valid (out_valid),
        .m_sol   (out_sol),
        .m_sof   (out_sof),
        .m_pix   (out_pix)
    );

endmodule

// File: rtl/bayer_gain_chk.sv
`timescale 1ns/1ps
module bayer_gain_chk #(
    parameter int P_W = 10
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           in_sof,
    input logic [P_W-1:0] in_pix,
    input logic           out_valid,
    input logic           out_sol,
    input logic           out_sof,
    input logic [P_W-1:0] out_pix
);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_pix == '0 && !out_sol && !out_sof));

    assert_valid_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    assert_sof_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> ($past(in_sof, 2) && $past(in_valid, 2)));

    assert_sof_is_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_sol);

    assert_zero_stays_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_pix, 2) == '0) |-> out_pix == '0);

endmodule

bind bayer_gain bayer_gain_chk #(.P_W(P_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_pix    (in_pix),
    .out_valid (out_valid),
    .out_sol   (out_sol),
    .out_sof   (out_sof),
    .out_pix   (out_pix)
);

// File: tb/bayer_gain_tb.sv
`timescale 1ns/1ps
module bayer_gain_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_sol = 1'b0, in_sof = 1'b0;
    logic [9:0] in_pix = '0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       out_valid, out_sol, out_sof;
    logic [9:0] out_pix;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    bayer_gain u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sol(in_sol), .in_sof(in_sof), .in_pix(in_pix),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .out_valid(out_valid), .out_sol(out_sol), .out_sof(out_sof), .out_pix(out_pix)
    );

    // reference model state
    int  m_stg [4];
    int  m_act [4];
    bit  m_seen;
    bit  m_row;
    bit  m_col_next;
    bit  e_v   [2];
    bit  e_sol [2];
    bit  e_sof [2];
    int  e_pix [2];

    function automatic int ref_chan(bit row, bit col);
        if (!row && !col) return 1;   // R
        if (!row &&  col) return 0;   // Gr
        if ( row && !col) return 3;   // Gb
        return 2;                     // B
    endfunction

    function automatic int ref_gain(int pix, int g);
        int r;
        r = (pix * g + 128) >> 8;
        return (r > 1023) ? 1023 : r;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            m_stg[i] = 256;
            m_act[i] = 256;
        end
        m_seen = 0; m_row = 0; m_col_next = 0;
        for (int i = 0; i < 2; i++) begin
            e_v[i] = 0; e_sol[i] = 0; e_sof[i] = 0; e_pix[i] = 0;
        end
    endtask

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            bit col, acc;
            int ch;
            check(cur_req, "out_valid", int'(out_valid), int'(e_v[1]));
            check(cur_req, "out_sol",   int'(out_sol),   int'(e_sol[1]));
            check(cur_req, "out_sof",   int'(out_sof),   int'(e_sof[1]));
            check(cur_req, "out_pix",   int'(out_pix),   e_pix[1]);
            e_v[1] = e_v[0]; e_sol[1] = e_sol[0]; e_sof[1] = e_sof[0]; e_pix[1] = e_pix[0];
            e_v[0] = 0; e_sol[0] = 0; e_sof[0] = 0; e_pix[0] = 0;
            if (in_valid) begin
                if (in_sof) begin
                    for (int i = 0; i < 4; i++) m_act[i] = m_stg[i];
                    m_row = 0; m_seen = 1; col = 0;
                end else if (in_sol) begin
                    if (m_seen) m_row = !m_row;
                    col = 0;
                end else begin
                    col = m_col_next;
                end
                acc = m_seen;
                if (acc) begin
                    ch = ref_chan(m_row, col);
                    m_col_next = !col;
                    e_v[0] = 1; e_sol[0] = in_sol; e_sof[0] = in_sof;
                    e_pix[0] = ref_gain(int'(in_pix), m_act[ch]);
                end
            end
            if (wr_en) begin
                int c;
                c = int'(wr_addr[2:1]);
                if (wr_addr[0]) m_stg[c] = (m_stg[c] & 255) | (int'(wr_data[2:0]) << 8);
                else            m_stg[c] = (m_stg[c] & 32'h700) | int'(wr_data);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        in_valid = 0; in_sol = 0; in_sof = 0; wr_en = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        tick();
    endtask

    task automatic set_gain(int ch, int g);
        wr({ch[1:0], 1'b0}, g[7:0]);
        wr({ch[1:0], 1'b1}, {5'b0, g[10:8]});
    endtask

    function automatic logic [9:0] pick(int mode);
        if (mode == 1) return 10'd1023;
        if (mode == 2) return 10'($urandom % 301);
        return 10'($urandom % 1024);
    endfunction

    task automatic send_line(int len, bit first, int mode, int gap);
        for (int i = 0; i < len; i++) begin
            in_valid = 1; in_sol = (i == 0); in_sof = (i == 0) && first;
            in_pix = pick(mode);
            tick();
            if (int'($urandom % 100) < gap) idle(1 + $urandom % 2);
        end
    endtask

    task automatic send_frame(int lines, int len, int mode, int gap);
        for (int l = 0; l < lines; l++) send_line(len, l == 0, mode, gap);
    endtask

    initial begin
        #3000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1bad5eed));
        model_reset();
        idle(3);
        #5;
        check("R1", "reset out_valid", int'(out_valid), 0);
        check("R1", "reset out_pix", int'(out_pix), 0);
        @(posedge clk); #1;
        rst_n = 1;
        idle(2);

        cur_req = "R9";
        send_line(6, 0, 0, 0);
        send_line(4, 0, 0, 0);
        idle(3);

        cur_req = "R1";
        send_frame(3, 6, 0, 0);
        idle(2);

        cur_req = "R7";
        send_line(8, 1, 0, 0);
        send_line(8, 0, 0, 0);
        set_gain(0, 12'h080);
        set_gain(1, 12'h1C0);
        set_gain(2, 12'h300);
        set_gain(3, 12'h0F0);
        send_line(8, 0, 0, 0);
        send_line(8, 0, 0, 0);
        idle(2);

        cur_req = "R2";
        send_frame(4, 8, 0, 0);
        idle(2);

        cur_req = "R6";
        send_line(5, 1, 2, 20);
        send_line(7, 0, 2, 20);
        send_line(3, 0, 2, 20);
        send_line(1, 0, 2, 20);
        send_line(6, 0, 2, 20);
        idle(2);

        cur_req = "R4";
        for (int c = 0; c < 4; c++) set_gain(c, 1);
        send_frame(2, 40, 2, 0);
        for (int c = 0; c < 4; c++) set_gain(c, 12'h180);
        send_frame(2, 20, 2, 0);
        idle(2);

        cur_req = "R3";
        for (int c = 0; c < 4; c++) begin
            wr({c[1:0], 1'b0}, 8'h00);
            wr({c[1:0], 1'b1}, 8'hF9);
        end
        send_frame(2, 10, 0, 0);
        idle(2);

        cur_req = "R5";
        for (int c = 0; c < 4; c++) begin
            wr({c[1:0], 1'b0}, 8'hFF);
            wr({c[1:0], 1'b1}, 8'hFF);
        end
        send_frame(2, 8, 1, 0);
        send_frame(2, 8, 0, 0);
        idle(2);

        cur_req = "R8";
        send_frame(3, 9, 0, 60);
        send_line(4, 1, 0, 0);
        @(negedge clk);
        rst_n = 0;
        idle(2);
        @(posedge clk); #1;
        rst_n = 1;
        cur_req = "R9";
        send_line(5, 0, 0, 0);
        idle(2);
        cur_req = "R1";
        send_frame(2, 6, 0, 0);
        idle(2);

        cur_req = "R2";
        for (int f = 0; f < 12; f++) begin
            for (int c = 0; c < 4; c++) set_gain(c, int'($urandom % 2048));
            send_frame(2 + $urandom % 4, 2 + $urandom % 9, 0, 15);
        end
        idle(4);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule